// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block merges many interrupt sources of a peripheral into one active-high interrupt pin, in two levels. Two groups of event sources sit at the second level: group A has six sources and group B has eleven. Each group keeps one sticky status bit and one enable bit per source. Each group reduces to one summary: the OR of its status bits ANDed with their enable bits. Group A's summary is also ANDed with a master-enable bit at bit 31 of its enable register. Group B has no such gate.

The two summaries occupy bits 0 and 1 of a ten-bit first-level status register. Bits 2 to 9 of that register capture eight direct first-level events. The first-level request is the OR of that status ANDed with a first-level enable register. The request reaches the pin through a clock-enabled flip-flop. That flip-flop is governed by a two-state machine that follows the pin-enable bit (bit 0 of the configuration register). In state PIN_TRACK the pin copies the request one cycle later. In state PIN_HOLD the pin keeps its value. A write of 1 to pin-enable moves PIN_HOLD to PIN_TRACK. A write of 0 moves PIN_TRACK to PIN_HOLD. Any other write leaves the state as it is.

Software uses a simple write port (enable, address, data) and a combinational read port. Register addresses are: 0 group A status, 1 group A enable, 2 group B status, 3 group B enable, 4 first-level status, 5 first-level enable, 6 configuration. Any other address reads 0.

Top module: `irq_two_level_agg`

## Requirements
- R1: After reset every status and enable register reads 0, pin-enable reads 0, the state is PIN_HOLD and `irq_o` is 0.
- R2: A group or direct event sets its status bit at the next clock edge, and the bit stays set. When an event and a write-1-to-clear of the same bit fall in one cycle, the bit ends up set.
- R3: Writing a status register clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R4: First-level status bit 0 is set one cycle after group A has a status bit whose enable bit is 1, but only while group A enable bit 31 (master) is 1.
- R5: First-level status bit 1 is set one cycle after group B has a status bit whose enable bit is 1. No master bit applies.
- R6: After a clear of first-level bit 0 or 1, that bit reads 0 for one cycle. It is set again on the following edge if its group summary is still 1.
- R7: First-level bits 2..9 capture direct events 0..7. The request is 1 when any first-level status bit has its first-level enable bit at 1.
- R8: In PIN_TRACK, `irq_o` equals the request of the previous cycle.
- R9: In PIN_HOLD, `irq_o` keeps its value whatever events occur and whatever is written to any interrupt register.
- R10: With pin-enable at 1, clearing all first-level status and then writing pin-enable 0 leaves `irq_o` at 0. It stays 0 when new events arrive.
- R11: With pin-enable at 1, clearing all first-level enable bits and then writing pin-enable 0 leaves `irq_o` at 0. The first-level status bits keep their values.
- R12: The read port returns each register at its address. Group A enable shows the master bit at bit 31, configuration shows pin-enable at bit 0, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_grp_a | input | 6 | Group A event pulses |
| ev_grp_b | input | 11 | Group B event pulses |
| ev_top | input | 8 | Direct first-level event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt pin, active high |

## Verification
The bench uses the default sizes: six group A sources, eleven group B sources and ten first-level bits. At these sizes every source bit can be swept one at a time. Each group A bit is run under all four combinations of its enable bit and the master bit. Each group B bit and each direct event is run with its enable on and off. The bench also drives event-versus-clear collisions, partial clears, the one-cycle gap when a summary bit is cleared and set again, and both pin-masking sequences, with the pin held frozen in between.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
    typedef enum logic [2:0] {
        REG_A_ST  = 3'd0,
        REG_A_EN  = 3'd1,
        REG_B_ST  = 3'd2,
        REG_B_EN  = 3'd3,
        REG_T_ST  = 3'd4,
        REG_T_EN  = 3'd5,
        REG_CFG   = 3'd6
    } reg_sel_e;

    typedef enum logic {
        PIN_HOLD  = 1'b0,
        PIN_TRACK = 1'b1
    } pin_state_e;

    localparam int MASTER_BIT = 31;
    localparam int PIN_EN_BIT = 0;
endpackage

// File: rtl/irq_group.sv
`timescale 1ns/1ps
module irq_group #(
    parameter int N          = 6,
    parameter bit HAS_MASTER = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr_mask,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic         master_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         master,
    output logic         summary
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | ev;
            if (en_we) enable <= en_wdata;
        end
    end

    generate
        if (HAS_MASTER) begin : g_master
            logic master_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     master_q <= 1'b0;
                else if (en_we) master_q <= master_wdata;
            end
            assign master  = master_q;
            assign summary = (|(status & enable)) & master_q;
        end else begin : g_plain
            logic unused_master;
            assign unused_master = master_wdata;
            assign master        = 1'b0;
            assign summary       = |(status & enable);
        end
    endgenerate
endmodule

// File: rtl/irq_top_level.sv
`timescale 1ns/1ps
module irq_top_level #(
    parameter int N_TOP = 10,
    localparam int N_EXT = N_TOP - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_a,
    input  logic             sum_b,
    input  logic [N_EXT-1:0] ev_ext,
    input  logic [N_TOP-1:0] clr_mask,
    input  logic             en_we,
    input  logic [N_TOP-1:0] en_wdata,
    output logic [N_TOP-1:0] status,
    output logic [N_TOP-1:0] enable,
    output logic             req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            // summary bits: a clear wins; a live summary re-sets on the next edge
            status[0] <= clr_mask[0] ? 1'b0 : (status[0] | sum_a);
            status[1] <= clr_mask[1] ? 1'b0 : (status[1] | sum_b);
            status[N_TOP-1:2] <= (status[N_TOP-1:2] & ~clr_mask[N_TOP-1:2]) | ev_ext;
            if (en_we) enable <= en_wdata;
        end
    end

    assign req = |(status & enable);
endmodule

// File: rtl/irq_pin_latch.sv
`timescale 1ns/1ps
module irq_pin_latch
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_pin_en,
    input  logic req,
    output logic pin_en,
    output logic irq
);
    pin_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PIN_HOLD:  if (cfg_we &&  cfg_pin_en) state_nxt = PIN_TRACK;
            PIN_TRACK: if (cfg_we && !cfg_pin_en) state_nxt = PIN_HOLD;
            default:   state_nxt = PIN_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIN_HOLD;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            unique case (state)
                PIN_TRACK: irq <= req;
                PIN_HOLD:  irq <= irq;
                default:   irq <= 1'b0;
            endcase
        end
    end

    assign pin_en = (state == PIN_TRACK);
endmodule

// File: rtl/irq_two_level_agg.sv
`timescale 1ns/1ps
module irq_two_level_agg
    import irq_agg_pkg::*;
#(
    parameter int N_A   = 6,
    parameter int N_B   = 11,
    parameter int N_TOP = 10,
    parameter int DW    = 32,
    parameter int AW    = 3,
    localparam int N_EXT = N_TOP - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_A-1:0]   ev_grp_a,
    input  logic [N_B-1:0]   ev_grp_b,
    input  logic [N_EXT-1:0] ev_top,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             irq_o
);
    logic [N_A-1:0]   a_status, a_enable, a_clr;
    logic [N_B-1:0]   b_status, b_enable, b_clr;
    logic [N_TOP-1:0] top_status, top_enable, top_clr;
    logic             a_master, b_master, sum_a, sum_b, top_req, pin_en;
    logic             unused_wr_bits, unused_b_master;

    assign unused_wr_bits  = ^wr_data[DW-2:N_B];
    assign unused_b_master = b_master;

    assign a_clr   = (wr_en && wr_addr == REG_A_ST) ? wr_data[N_A-1:0]   : '0;
    assign b_clr   = (wr_en && wr_addr == REG_B_ST) ? wr_data[N_B-1:0]   : '0;
    assign top_clr = (wr_en && wr_addr == REG_T_ST) ? wr_data[N_TOP-1:0] : '0;

    irq_group #(.N(N_A), .HAS_MASTER(1'b1)) u_grp_a (
        .clk(clk), .rst_n(rst_n), .ev(ev_grp_a), .clr_mask(a_clr),
        .en_we(wr_en && wr_addr == REG_A_EN), .en_wdata(wr_data[N_A-1:0]),
        .master_wdata(wr_data[MASTER_BIT]),
        .status(a_status), .enable(a_enable), .master(a_master), .summary(sum_a)
    );

    irq_group #(.N(N_B), .HAS_MASTER(1'b0)) u_grp_b (
        .clk(clk), .rst_n(rst_n), .ev(ev_grp_b), .clr_mask(b_clr),
        .en_we(wr_en && wr_addr == REG_B_EN), .en_wdata(wr_data[N_B-1:0]),
        .master_wdata(1'b0),
        .status(b_status), .enable(b_enable), .master(b_master), .summary(sum_b)
    );

    irq_top_level #(.N_TOP(N_TOP)) u_top (
        .clk(clk), .rst_n(rst_n), .sum_a(sum_a), .sum_b(sum_b), .ev_ext(ev_top),
        .clr_mask(top_clr), .en_we(wr_en && wr_addr == REG_T_EN),
        .en_wdata(wr_data[N_TOP-1:0]),
        .status(top_status), .enable(top_enable), .req(top_req)
    );

    irq_pin_latch u_pin (
        .clk(clk), .rst_n(rst_n), .cfg_we(wr_en && wr_addr == REG_CFG),
        .cfg_pin_en(wr_data[PIN_EN_BIT]), .req(top_req),
        .pin_en(pin_en), .irq(irq_o)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_A_ST: rd_data[N_A-1:0]   = a_status;
            REG_A_EN: begin
                rd_data[N_A-1:0]      = a_enable;
                rd_data[MASTER_BIT]   = a_master;
            end
            REG_B_ST: rd_data[N_B-1:0]   = b_status;
            REG_B_EN: rd_data[N_B-1:0]   = b_enable;
            REG_T_ST: rd_data[N_TOP-1:0] = top_status;
            REG_T_EN: rd_data[N_TOP-1:0] = top_enable;
            REG_CFG:  rd_data[PIN_EN_BIT] = pin_en;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_two_level_agg_chk.sv
`timescale 1ns/1ps
module irq_two_level_agg_chk #(
    parameter int N_A   = 6,
    parameter int N_TOP = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             pin_en,
    input logic             top_req,
    input logic             sum_a,
    input logic             sum_b,
    input logic [N_TOP-1:0] top_status,
    input logic [N_TOP-1:0] top_clr,
    input logic [N_A-1:0]   ev_grp_a,
    input logic [N_A-1:0]   a_status
);
    p_pin_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_en) |-> (irq_o == $past(top_req)));

    p_pin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pin_en) |-> $stable(irq_o));

    p_sum_a_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_a && !top_clr[0]) |=> top_status[0]);

    p_sum_b_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_b && !top_clr[1]) |=> top_status[1]);

    p_clear_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (top_clr[0] || top_clr[1]) |=>
            ((top_status[1:0] & $past(top_clr[1:0])) == 2'b00));

    p_event_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_grp_a) |=> ((a_status & $past(ev_grp_a)) == $past(ev_grp_a)));
endmodule

bind irq_two_level_agg irq_two_level_agg_chk #(.N_A(N_A), .N_TOP(N_TOP)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pin_en(pin_en), .top_req(top_req),
    .sum_a(sum_a), .sum_b(sum_b), .top_status(top_status), .top_clr(top_clr),
    .ev_grp_a(ev_grp_a), .a_status(a_status)
);

// File: tb/irq_two_level_agg_tb.sv
`timescale 1ns/1ps
module irq_two_level_agg_tb;
    localparam logic [2:0] A_ST = 3'd0, A_EN = 3'd1, B_ST = 3'd2, B_EN = 3'd3,
                           T_ST = 3'd4, T_EN = 3'd5, CFG = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ev_grp_a = '0;
    logic [10:0] ev_grp_b = '0;
    logic [7:0]  ev_top = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_two_level_agg u_dut (
        .clk(clk), .rst_n(rst_n), .ev_grp_a(ev_grp_a), .ev_grp_b(ev_grp_b),
        .ev_top(ev_top), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic chk_pin(input string tag, input logic exp);
        chk(tag, {31'd0, irq_o}, {31'd0, exp});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int a = 0; a < 8; a++) rd("R1 reset read", a[2:0], 32'h0);
        chk_pin("R1 reset pin", 1'b0);

        wr(CFG, 32'h1);
        rd("R12 cfg readback", CFG, 32'h1);

        // group A sweep: bit, enable, master (R2, R4, R8, R3)
        for (int k = 0; k < 6; k++) begin
            for (int m = 0; m < 2; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [31:0] en_w;
                    logic        gate;
                    en_w = (32'(m) << 31) | (e ? (32'h1 << k) : 32'h0);
                    gate = (m == 1) && (e == 1);
                    wr(A_EN, en_w);
                    rd("R12 A enable readback", A_EN, en_w);
                    wr(T_EN, 32'h1);
                    ev_grp_a = 6'(1 << k); tick(); ev_grp_a = '0;
                    rd("R2 A status set", A_ST, 32'h1 << k);
                    tick();
                    rd("R4 top bit0 from group A", T_ST, {31'd0, gate});
                    tick();
                    chk_pin("R8 pin follows group A", gate);
                    wr(A_ST, 32'h1 << k);
                    rd("R3 A status cleared", A_ST, 32'h0);
                    wr(T_ST, 32'h3);
                    tick();
                    chk_pin("R8 pin drops", 1'b0);
                end
            end
        end

        // group B sweep, no master (R5)
        for (int k = 0; k < 11; k++) begin
            for (int e = 0; e < 2; e++) begin
                wr(B_EN, e ? (32'h1 << k) : 32'h0);
                wr(T_EN, 32'h2);
                ev_grp_b = 11'(1 << k); tick(); ev_grp_b = '0;
                rd("R2 B status set", B_ST, 32'h1 << k);
                tick();
                rd("R5 top bit1 from group B", T_ST, {30'd0, e[0], 1'b0});
                tick();
                chk_pin("R8 pin follows group B", e[0]);
                wr(B_ST, 32'h1 << k);
                rd("R3 B status cleared", B_ST, 32'h0);
                wr(T_ST, 32'h3);
                tick();
            end
        end

        // event beats clear in same cycle (R2)
        ev_grp_a = 6'b000100;
        wr(A_ST, 32'h4);
        ev_grp_a = '0;
        rd("R2 event wins over clear", A_ST, 32'h4);
        // partial W1C (R3)
        ev_grp_a = 6'b010011; tick(); ev_grp_a = '0;
        wr(A_ST, 32'h11);
        rd("R3 partial clear", A_ST, 32'h06);
        wr(A_ST, 32'h3F);

        // re-set gap after clearing a live summary (R6)
        wr(A_EN, 32'h8000_0001);
        ev_grp_a = 6'b000001; tick(); ev_grp_a = '0;
        tick();
        rd("R6 bit0 set", T_ST, 32'h1);
        wr(T_ST, 32'h1);
        rd("R6 bit0 cleared for one cycle", T_ST, 32'h0);
        tick();
        rd("R6 bit0 re-set by live summary", T_ST, 32'h1);
        wr(A_ST, 32'h3F);
        wr(A_EN, 32'h0);
        wr(T_ST, 32'h3FF);
        tick();

        // direct first-level events (R7)
        for (int j = 0; j < 8; j++) begin
            for (int e = 0; e < 2; e++) begin
                wr(T_EN, e ? (32'h4 << j) : 32'h1);
                ev_top = 8'(1 << j); tick(); ev_top = '0;
                rd("R7 direct event captured", T_ST, 32'h4 << j);
                tick();
                chk_pin("R7 request from direct event", e[0]);
                wr(T_ST, 32'h3FF);
                tick();
            end
        end

        // frozen pin (R9)
        wr(T_EN, 32'h3FC);
        ev_top = 8'h01; tick(); ev_top = '0;
        tick();
        chk_pin("R9 pin high before freeze", 1'b1);
        wr(CFG, 32'h0);
        wr(T_EN, 32'h0);
        wr(T_ST, 32'h3FF);
        repeat (3) tick();
        chk_pin("R9 pin held high while frozen", 1'b1);
        rd("R12 cfg reads 0", CFG, 32'h0);
        wr(CFG, 32'h1);
        tick();
        chk_pin("R8 pin follows after unfreeze", 1'b0);

        // deassert and clear sequence (R10)
        wr(T_EN, 32'h3FC);
        ev_top = 8'h02; tick(); ev_top = '0;
        tick();
        chk_pin("R10 pin high at start", 1'b1);
        wr(T_ST, 32'h3FF);
        wr(CFG, 32'h0);
        tick();
        chk_pin("R10 pin low after sequence", 1'b0);
        ev_top = 8'h04; tick(); ev_top = '0;
        repeat (2) tick();
        chk_pin("R10 pin stays low on new event", 1'b0);

        // mask sequence preserving status (R11)
        wr(CFG, 32'h1);
        tick();
        chk_pin("R11 pin high at start", 1'b1);
        wr(T_EN, 32'h0);
        wr(CFG, 32'h0);
        repeat (2) tick();
        chk_pin("R11 pin low after masking", 1'b0);
        rd("R11 status kept", T_ST, 32'h10);
        wr(T_EN, 32'h3FC);
        wr(CFG, 32'h1);
        tick();
        chk_pin("R11 pin returns on re-enable", 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule